// File: doc/BRIEF.md
# Programmable Windowed Timing Output

This block derives one user-defined timing pulse from the pixel and line counters of a video timing generator. A horizontal window covers a range of pixel positions within every line, and a vertical window covers a range of line numbers within every field. A small combine field selects the rule that merges the two windows: both, either, or exactly one. A polarity bit flips the final level.

The pixel counter, the line counter and a field flag come in from the surrounding timing generator. The window and mode settings come in as plain register values. The result leaves on one registered pin. The settings are copied into an internal shadow at the first pixel of each frame, so a frame never shows a mix of old and new settings. The first pixel of a frame is the cycle with pixel 0, line 0 and the field flag low. Line numbers count from 0 within each field, so in interlaced formats the same vertical window repeats in both fields.

Top module: `win_timing_out`

## Requirements
- R1: After reset, `win_out` is 0. Until the first frame start, the shadowed settings behave as all zero: an empty window, no combine bit set and polarity 0. Because of this, `win_out` stays 0 until that frame start, whatever `cfg_*` holds.
- R2: The horizontal window is active when `cfg_h_start <= pix_cnt < cfg_h_stop`.
- R3: The vertical window is active when `cfg_v_start <= line_cnt < cfg_v_stop`. `line_cnt` is the line number within the current field.
- R4: When `cfg_mode` bit 0 (AND) is set, the raw signal is active only while both windows are active.
- R5: When bit 1 (OR) is the highest-priority bit set, the raw signal is active while either window is active.
- R6: When bit 2 (XOR) is the only bit set, the raw signal is active when exactly one window is active.
- R7: When `cfg_mode` is 0, the raw signal follows the horizontal window alone.
- R8: When several mode bits are set, AND takes priority over OR, and OR takes priority over XOR.
- R9: `win_out` equals the raw signal XOR `cfg_invert`, so `cfg_invert` = 1 makes the output active low.
- R10: `win_out` is registered and reflects the counter values presented one clock earlier.
- R11: New settings apply from the frame-start cycle onward. That cycle is `pix_cnt`=0, `line_cnt`=0, `field`=0, and it already uses the new settings. Changes made at any other time have no effect until the next frame start.
- R12: A counter position of 0/0 with `field`=1 (start of the second field) does not load new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_cnt | input | PIX_W | Current pixel position in the line |
| line_cnt | input | LINE_W | Current line number in the field |
| field | input | 1 | Field flag, 0 for the first (odd) field |
| cfg_h_start | input | PIX_W | Horizontal window first pixel |
| cfg_h_stop | input | PIX_W | Horizontal window end pixel (exclusive) |
| cfg_v_start | input | LINE_W | Vertical window first line |
| cfg_v_stop | input | LINE_W | Vertical window end line (exclusive) |
| cfg_mode | input | 3 | Combine bits: bit0 AND, bit1 OR, bit2 XOR |
| cfg_invert | input | 1 | Output polarity inversion |
| win_out | output | 1 | Registered timing output |

## Verification
The embedded properties check the following on every cycle: the output level for the AND, OR, XOR and no-combine rules against the window comparators of the previous cycle, and that the shadowed settings stay unchanged away from frame start. Some behaviour can only be shown by the bench scenarios. The sweeps over every mode and polarity across whole frames show the window boundaries and the priority among combine bits. They also show that settings changed mid-frame, or at the second-field start, are deferred to the next frame. The reset scenario shows that the output holds inactive until the first frame start.

// File: rtl/win_timing_out.sv
module win_timing_out #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              field,
  input  logic [PIX_W-1:0]  cfg_h_start,
  input  logic [PIX_W-1:0]  cfg_h_stop,
  input  logic [LINE_W-1:0] cfg_v_start,
  input  logic [LINE_W-1:0] cfg_v_stop,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_invert,
  output logic              win_out
);

  localparam int MODE_AND = 0;
  localparam int MODE_OR  = 1;
  localparam int MODE_XOR = 2;

  logic [PIX_W-1:0]  sh_hs, sh_he;
  logic [LINE_W-1:0] sh_vs, sh_ve;
  logic [2:0]        sh_mode;
  logic              sh_inv;

  // R11/R12: only the first pixel of the first field is a frame start
  wire frame_start = (pix_cnt == '0) && (line_cnt == '0) && !field;

  wire [PIX_W-1:0]  eff_hs   = frame_start ? cfg_h_start : sh_hs;
  wire [PIX_W-1:0]  eff_he   = frame_start ? cfg_h_stop  : sh_he;
  wire [LINE_W-1:0] eff_vs   = frame_start ? cfg_v_start : sh_vs;
  wire [LINE_W-1:0] eff_ve   = frame_start ? cfg_v_stop  : sh_ve;
  wire [2:0]        eff_mode = frame_start ? cfg_mode    : sh_mode;
  wire              eff_inv  = frame_start ? cfg_invert  : sh_inv;

  wire h_act = (pix_cnt >= eff_hs) && (pix_cnt < eff_he);
  wire v_act = (line_cnt >= eff_vs) && (line_cnt < eff_ve);

  logic raw;
  always_comb begin
    if (eff_mode[MODE_AND])      raw = h_act & v_act;
    else if (eff_mode[MODE_OR])  raw = h_act | v_act;
    else if (eff_mode[MODE_XOR]) raw = h_act ^ v_act;
    else                         raw = h_act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_hs   <= '0;
      sh_he   <= '0;
      sh_vs   <= '0;
      sh_ve   <= '0;
      sh_mode <= '0;
      sh_inv  <= 1'b0;
      win_out <= 1'b0;
    end else begin
      if (frame_start) begin
        sh_hs   <= cfg_h_start;
        sh_he   <= cfg_h_stop;
        sh_vs   <= cfg_v_start;
        sh_ve   <= cfg_v_stop;
        sh_mode <= cfg_mode;
        sh_inv  <= cfg_invert;
      end
      win_out <= raw ^ eff_inv;
    end
  end

  p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode[MODE_AND] && !(h_act && v_act)) |=> (win_out == $past(eff_inv)));

  p_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == 3'b010 && (h_act || v_act)) |=> (win_out != $past(eff_inv)));

  p_xor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == 3'b100 && h_act && v_act) |=> (win_out == $past(eff_inv)));

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == 3'b000) |=> (win_out == ($past(h_act) ^ $past(eff_inv))));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable({sh_hs, sh_he, sh_vs, sh_ve, sh_mode, sh_inv}));

endmodule

// File: tb/win_timing_out_bench.sv
module win_timing_out_bench;
  localparam int PW = 4, LW = 3, NPIX = 10, NLIN = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] pix = '0, hs = '0, he = '0;
  logic [LW-1:0] lin = '0, vs = '0, ve = '0;
  logic fld = 1'b0, inv = 1'b0, win;
  logic [2:0] mode = '0;

  always #2.5 clk = ~clk;

  win_timing_out #(.PIX_W(PW), .LINE_W(LW)) u_win_timing_out (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix), .line_cnt(lin), .field(fld),
    .cfg_h_start(hs), .cfg_h_stop(he), .cfg_v_start(vs), .cfg_v_stop(ve),
    .cfg_mode(mode), .cfg_invert(inv), .win_out(win));

  int checks = 0, fails = 0;
  bit done = 0;
  // bench copy of the frame-latched settings (R11)
  int b_hs = 0, b_he = 0, b_vs = 0, b_ve = 0, b_mode = 0;
  bit b_inv = 0;
  bit pend = 0, pend_exp = 0;
  string pend_tag = "";

  function automatic bit model(int p, int l);
    bit h, v, r;
    h = (p >= b_hs) && (p < b_he);   // R2
    v = (l >= b_vs) && (l < b_ve);   // R3
    if (b_mode[0]) r = h & v;        // R4, R8
    else if (b_mode[1]) r = h | v;   // R5, R8
    else if (b_mode[2]) r = h ^ v;   // R6
    else r = h;                      // R7
    return r ^ b_inv;                // R9
  endfunction

  function automatic string tagf();
    string t;
    case (b_mode)
      0: t = "R7/R2"; 1: t = "R4/R3"; 2: t = "R5"; 4: t = "R6";
      default: t = "R8";
    endcase
    if (b_inv) t = {t, "/R9"};
    return {t, "/R10"};
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: win_out=%0b expected %0b", tag, act, exp);
    end
  endtask

  // one output check per cycle, one cycle after the counters were driven (R10)
  task automatic step(input int p, input int l, input bit f, input string extra);
    @(negedge clk);
    if (pend) check(win, pend_exp, pend_tag);
    pix = PW'(p); lin = LW'(l); fld = f;
    if (rst_n && p == 0 && l == 0 && !f) begin   // R11, R12
      b_hs = hs; b_he = he; b_vs = vs; b_ve = ve; b_mode = mode; b_inv = inv;
    end
    pend = rst_n;
    pend_exp = model(p, l);
    pend_tag = {tagf(), extra};
  endtask

  task automatic frame();
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < NLIN; l++)
        for (int p = 0; p < NPIX; p++) step(p, l, f[0], "");
  endtask

  task automatic setcfg(input int a, input int b, input int c, input int d,
                        input int m, input bit i);
    hs = PW'(a); he = PW'(b); vs = LW'(c); ve = LW'(d); mode = 3'(m); inv = i;
  endtask

  initial begin
    setcfg(1, 9, 0, 6, 0, 1);
    pix = 4'd3; lin = 3'd2;
    repeat (3) @(negedge clk);
    check(win, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    // R1: settings not yet latched, output stays low mid-frame
    for (int k = 0; k < 4; k++) step(3 + k, 2, 1'b0, "/R1");
    // sweep every mode and polarity over full frames
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 2; i++) begin
        setcfg(2, 7, 1, 4, m, i[0]);
        frame();
      end
    // window boundaries: full and last-pixel/last-line windows
    setcfg(0, 10, 0, 6, 1, 0); frame();
    setcfg(9, 10, 5, 6, 2, 0); frame();
    setcfg(9, 10, 5, 6, 4, 1); frame();
    setcfg(0, 1, 0, 1, 1, 0);  frame();
    // R11: change mid field 0; R12: change before field 1 start
    setcfg(2, 5, 1, 3, 0, 0);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < NLIN; l++)
        for (int p = 0; p < NPIX; p++) begin
          if (f == 0 && l == 2 && p == 4) setcfg(0, 10, 0, 6, 2, 1);
          if (f == 0 && l == NLIN - 1 && p == NPIX - 1) setcfg(3, 8, 0, 6, 4, 0);
          step(p, l, f[0], "/R11/R12");
        end
    frame();  // new settings now take effect (R11)
    step(0, 1, 1'b0, "");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule